// File: doc/BRIEF.md
# Slotted Ring Stop

This block is a single stop on a one-way slotted ring. Every clock a slot arrives from the stop upstream. The slot is either empty or holds a message made of a sender number, a recipient number, a command code, an address and a data word. The stop registers one outgoing slot per cycle toward the next stop downstream. Two stops can be wired back to back to serve the two directions of a bidirectional ring that joins cores, cache banks, memory controllers and I/O.

A message addressed to this stop is handed to the local agent through a valid/ready receive port. When the agent accepts it, the stop puts an empty slot on the ring in its place. When the agent is not ready, the message stays on the ring and goes round again. Messages from the local agent wait in a small transmit queue and enter the ring only by taking over an empty slot. A slot that a local receive frees in a given cycle can carry the stop's own message in that same cycle.

A debug capture unit watches incoming occupied slots and compares the command and recipient fields with programmable values under bit masks. Matching messages are stored in a small buffer that a debug agent reads through a valid/pop port.

Each cycle the slot logic picks one of four actions:
- ACT_PASS_EMPTY: an empty slot goes through.
- ACT_FORWARD: a message goes on unchanged.
- ACT_DRAIN: a consumed message is replaced by an empty slot.
- ACT_INSERT: the queue head is placed in an empty or freed slot.

Both the transmit queue and the capture buffer are built from one queue whose state register has three states: Q_EMPTY, Q_PART and Q_FULL. Its transitions are:
- Q_EMPTY to Q_PART on a push, or to Q_FULL when the depth is one.
- Q_PART to Q_FULL on a push without a pop that fills the last entry.
- Q_PART to Q_EMPTY on a pop without a push that removes the last entry.
- Q_FULL to Q_PART on a pop, or to Q_EMPTY when the depth is one.

Top module: `ring_stop`

## Requirements
- R1: After reset the downstream slot is empty (dn_vld=0), tx_ready is 1 and cap_valid is 0.
- R2: An occupied incoming slot whose recipient differs from STOP_ID appears on the downstream outputs one cycle later with all fields unchanged.
- R3: An occupied incoming slot whose recipient equals STOP_ID raises rx_valid in the same cycle, with rx_src, rx_cmd, rx_addr and rx_data equal to the slot's fields. If rx_ready is 1 and nothing is queued for transmit, the downstream slot one cycle later is empty.
- R4: If a slot addressed to STOP_ID arrives while rx_ready is 0, the slot is forwarded unchanged one cycle later and is not lost.
- R5: A queued message leaves only in an empty slot. While occupied slots that are not consumed keep arriving, the head waits. In the cycle after an empty slot arrives, the downstream slot carries the message with sender field STOP_ID.
- R6: When a slot addressed to STOP_ID is accepted (rx_valid and rx_ready) while a message is queued, the queued message is sent downstream in that same slot one cycle later.
- R7: The transmit queue holds TXQ_DEPTH messages and sends them in push order. tx_ready is 0 when it is full, and a message offered then is discarded.
- R8: While cap_en is 1, an occupied incoming slot is captured when ((cmd ^ cap_cmd_val) & cap_cmd_mask) == 0 and ((dst ^ cap_dst_val) & cap_dst_mask) == 0. Captured messages are read in arrival order, and cap_pop removes the head.
- R9: The capture buffer holds CAP_DEPTH messages. Matches that arrive while it is full are dropped, and the stored ones are kept.
- R10: While cap_en is 0, nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_vld | input | 1 | Incoming slot occupied |
| up_src | input | ID_W | Incoming sender number |
| up_dst | input | ID_W | Incoming recipient number |
| up_cmd | input | CMD_W | Incoming command |
| up_addr | input | ADDR_W | Incoming address |
| up_data | input | DATA_W | Incoming data |
| dn_vld | output | 1 | Outgoing slot occupied (registered) |
| dn_src | output | ID_W | Outgoing sender number |
| dn_dst | output | ID_W | Outgoing recipient number |
| dn_cmd | output | CMD_W | Outgoing command |
| dn_addr | output | ADDR_W | Outgoing address |
| dn_data | output | DATA_W | Outgoing data |
| tx_valid | input | 1 | Local message offered |
| tx_ready | output | 1 | Transmit queue has room |
| tx_dst | input | ID_W | Local message recipient |
| tx_cmd | input | CMD_W | Local message command |
| tx_addr | input | ADDR_W | Local message address |
| tx_data | input | DATA_W | Local message data |
| rx_valid | output | 1 | Message for this stop present |
| rx_ready | input | 1 | Local agent accepts message |
| rx_src | output | ID_W | Received sender number |
| rx_cmd | output | CMD_W | Received command |
| rx_addr | output | ADDR_W | Received address |
| rx_data | output | DATA_W | Received data |
| cap_en | input | 1 | Capture enable |
| cap_cmd_val | input | CMD_W | Command compare value |
| cap_cmd_mask | input | CMD_W | Command compare mask |
| cap_dst_val | input | ID_W | Recipient compare value |
| cap_dst_mask | input | ID_W | Recipient compare mask |
| cap_valid | output | 1 | Captured message available |
| cap_pop | input | 1 | Remove captured head |
| cap_src | output | ID_W | Captured sender |
| cap_dst | output | ID_W | Captured recipient |
| cap_cmd | output | CMD_W | Captured command |
| cap_addr | output | ADDR_W | Captured address |
| cap_data | output | DATA_W | Captured data |

## Verification
On every cycle the assertions check that foreign traffic passes unchanged and that a refused local message stays on the ring. They also check that each insertion carries this stop's sender number and the queue head, that a waiting head stays stable, and that neither queue grows past full or captures while disabled. Only the bench's scenarios can show the results that need a history of stimulus. These are the exact cycle in which a held message finally leaves, the push order of a full transmit queue, the mask-selected contents of the capture buffer, and which matches a full buffer drops.

// File: rtl/ring_stop_pkg.sv
package ring_stop_pkg;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } q_state_t;

    typedef enum logic [1:0] {
        ACT_PASS_EMPTY = 2'd0,
        ACT_FORWARD    = 2'd1,
        ACT_DRAIN      = 2'd2,
        ACT_INSERT     = 2'd3
    } slot_act_t;

endpackage

// File: rtl/ring_fifo.sv
module ring_fifo
    import ring_stop_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    output logic             push_ready,
    input  logic             pop,
    output logic             pop_valid,
    output logic [WIDTH-1:0] pop_data
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    q_state_t         state_q, state_d;
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign do_push = push && (state_q != Q_FULL);
    assign do_pop  = pop  && (state_q != Q_EMPTY);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: begin
                if (do_push) state_d = (DEPTH == 1) ? Q_FULL : Q_PART;
            end
            Q_PART: begin
                if (do_push && !do_pop && cnt_q == ONE_LEFT)
                    state_d = Q_FULL;
                else if (do_pop && !do_push && cnt_q == CNT_W'(1))
                    state_d = Q_EMPTY;
            end
            Q_FULL: begin
                if (do_pop) state_d = (DEPTH == 1) ? Q_EMPTY : Q_PART;
            end
            default: state_d = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                mem[wr_q] <= push_data;
                wr_q      <= (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
            end
            if (do_pop)
                rd_q <= (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        push_ready = (state_q != Q_FULL);
        pop_valid  = (state_q != Q_EMPTY);
        pop_data   = mem[rd_q];
    end

    // R7 / R9: a full queue refuses writes; nothing is overwritten
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_FULL && push && !pop) |=> (state_q == Q_FULL && $stable(wr_q)));

    // R7: a waiting head entry is held stable until it is popped
    p_head_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && !pop) |=> (pop_valid && $stable(pop_data)));

endmodule

// File: rtl/ring_slot_mux.sv
module ring_slot_mux
    import ring_stop_pkg::*;
#(
    parameter int ID_W    = 3,
    parameter int CMD_W   = 4,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int STOP_ID = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [ID_W-1:0]   in_src,
    input  logic [ID_W-1:0]   in_dst,
    input  logic [CMD_W-1:0]  in_cmd,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              rx_ready,
    output logic              rx_valid,
    input  logic              tx_avail,
    input  logic [ID_W-1:0]   tx_dst,
    input  logic [CMD_W-1:0]  tx_cmd,
    input  logic [ADDR_W-1:0] tx_addr,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_take,
    output logic              out_vld,
    output logic [ID_W-1:0]   out_src,
    output logic [ID_W-1:0]   out_dst,
    output logic [CMD_W-1:0]  out_cmd,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);

    localparam logic [ID_W-1:0] MY_ID = ID_W'(STOP_ID);

    slot_act_t act;
    logic      for_me, consumed;

    always_comb begin
        for_me   = in_vld && (in_dst == MY_ID);
        consumed = for_me && rx_ready;
        if ((!in_vld || consumed) && tx_avail) act = ACT_INSERT;
        else if (consumed)                     act = ACT_DRAIN;
        else if (in_vld)                       act = ACT_FORWARD;
        else                                   act = ACT_PASS_EMPTY;
    end

    always_comb begin
        rx_valid = for_me;
        tx_take  = (act == ACT_INSERT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_src  <= '0;
            out_dst  <= '0;
            out_cmd  <= '0;
            out_addr <= '0;
            out_data <= '0;
        end else begin
            unique case (act)
                ACT_INSERT: begin
                    out_vld  <= 1'b1;
                    out_src  <= MY_ID;
                    out_dst  <= tx_dst;
                    out_cmd  <= tx_cmd;
                    out_addr <= tx_addr;
                    out_data <= tx_data;
                end
                ACT_FORWARD: begin
                    out_vld  <= 1'b1;
                    out_src  <= in_src;
                    out_dst  <= in_dst;
                    out_cmd  <= in_cmd;
                    out_addr <= in_addr;
                    out_data <= in_data;
                end
                ACT_DRAIN, ACT_PASS_EMPTY: begin
                    out_vld  <= 1'b0;
                end
                default: out_vld <= 1'b0;
            endcase
        end
    end

    p_fwd_foreign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_dst != MY_ID) |=>
        (out_vld && out_src == $past(in_src) && out_dst == $past(in_dst) &&
         out_cmd == $past(in_cmd) && out_addr == $past(in_addr) &&
         out_data == $past(in_data)));

    p_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !tx_avail) |=> !out_vld);

    p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=>
        (out_vld && out_dst == MY_ID && out_data == $past(in_data)));

    p_insert_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> (out_vld && out_src == MY_ID && out_dst == $past(tx_dst) &&
                     out_data == $past(tx_data)));

    p_reuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && tx_avail) |-> tx_take);

endmodule

// File: rtl/ring_capture.sv
module ring_capture #(
    parameter int ID_W      = 3,
    parameter int CMD_W     = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int CAP_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CMD_W-1:0]  cmd_val,
    input  logic [CMD_W-1:0]  cmd_mask,
    input  logic [ID_W-1:0]   dst_val,
    input  logic [ID_W-1:0]   dst_mask,
    input  logic              in_vld,
    input  logic [ID_W-1:0]   in_src,
    input  logic [ID_W-1:0]   in_dst,
    input  logic [CMD_W-1:0]  in_cmd,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              pop,
    output logic              valid,
    output logic [ID_W-1:0]   out_src,
    output logic [ID_W-1:0]   out_dst,
    output logic [CMD_W-1:0]  out_cmd,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);

    localparam int MSG_W = 2 * ID_W + CMD_W + ADDR_W + DATA_W;

    logic             hit;
    logic             room;
    logic [MSG_W-1:0] head;

    always_comb begin
        hit = en && in_vld &&
              (((in_cmd ^ cmd_val) & cmd_mask) == '0) &&
              (((in_dst ^ dst_val) & dst_mask) == '0);
    end

    ring_fifo #(.WIDTH(MSG_W), .DEPTH(CAP_DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (hit),
        .push_data  ({in_src, in_dst, in_cmd, in_addr, in_data}),
        .push_ready (room),
        .pop        (pop),
        .pop_valid  (valid),
        .pop_data   (head)
    );

    assign {out_src, out_dst, out_cmd, out_addr, out_data} = head;

    p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !valid) |=> !valid);

    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!room && hit && !pop) |=> (valid && $stable(out_data)));

endmodule

// File: rtl/ring_stop.sv
module ring_stop #(
    parameter int ID_W      = 3,
    parameter int CMD_W     = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int STOP_ID   = 2,
    parameter int TXQ_DEPTH = 4,
    parameter int CAP_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_vld,
    input  logic [ID_W-1:0]   up_src,
    input  logic [ID_W-1:0]   up_dst,
    input  logic [CMD_W-1:0]  up_cmd,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [DATA_W-1:0] up_data,
    output logic              dn_vld,
    output logic [ID_W-1:0]   dn_src,
    output logic [ID_W-1:0]   dn_dst,
    output logic [CMD_W-1:0]  dn_cmd,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [ID_W-1:0]   tx_dst,
    input  logic [CMD_W-1:0]  tx_cmd,
    input  logic [ADDR_W-1:0] tx_addr,
    input  logic [DATA_W-1:0] tx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [ID_W-1:0]   rx_src,
    output logic [CMD_W-1:0]  rx_cmd,
    output logic [ADDR_W-1:0] rx_addr,
    output logic [DATA_W-1:0] rx_data,
    input  logic              cap_en,
    input  logic [CMD_W-1:0]  cap_cmd_val,
    input  logic [CMD_W-1:0]  cap_cmd_mask,
    input  logic [ID_W-1:0]   cap_dst_val,
    input  logic [ID_W-1:0]   cap_dst_mask,
    output logic              cap_valid,
    input  logic              cap_pop,
    output logic [ID_W-1:0]   cap_src,
    output logic [ID_W-1:0]   cap_dst,
    output logic [CMD_W-1:0]  cap_cmd,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);

    localparam int TXM_W = ID_W + CMD_W + ADDR_W + DATA_W;

    logic              q_avail, q_take;
    logic [TXM_W-1:0]  q_head;
    logic [ID_W-1:0]   h_dst;
    logic [CMD_W-1:0]  h_cmd;
    logic [ADDR_W-1:0] h_addr;
    logic [DATA_W-1:0] h_data;

    ring_fifo #(.WIDTH(TXM_W), .DEPTH(TXQ_DEPTH)) u_txq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (tx_valid),
        .push_data  ({tx_dst, tx_cmd, tx_addr, tx_data}),
        .push_ready (tx_ready),
        .pop        (q_take),
        .pop_valid  (q_avail),
        .pop_data   (q_head)
    );

    assign {h_dst, h_cmd, h_addr, h_data} = q_head;

    ring_slot_mux #(
        .ID_W(ID_W), .CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .STOP_ID(STOP_ID)
    ) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (up_vld),
        .in_src   (up_src),
        .in_dst   (up_dst),
        .in_cmd   (up_cmd),
        .in_addr  (up_addr),
        .in_data  (up_data),
        .rx_ready (rx_ready),
        .rx_valid (rx_valid),
        .tx_avail (q_avail),
        .tx_dst   (h_dst),
        .tx_cmd   (h_cmd),
        .tx_addr  (h_addr),
        .tx_data  (h_data),
        .tx_take  (q_take),
        .out_vld  (dn_vld),
        .out_src  (dn_src),
        .out_dst  (dn_dst),
        .out_cmd  (dn_cmd),
        .out_addr (dn_addr),
        .out_data (dn_data)
    );

    assign rx_src  = up_src;
    assign rx_cmd  = up_cmd;
    assign rx_addr = up_addr;
    assign rx_data = up_data;

    ring_capture #(
        .ID_W(ID_W), .CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CAP_DEPTH(CAP_DEPTH)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cap_en),
        .cmd_val  (cap_cmd_val),
        .cmd_mask (cap_cmd_mask),
        .dst_val  (cap_dst_val),
        .dst_mask (cap_dst_mask),
        .in_vld   (up_vld),
        .in_src   (up_src),
        .in_dst   (up_dst),
        .in_cmd   (up_cmd),
        .in_addr  (up_addr),
        .in_data  (up_data),
        .pop      (cap_pop),
        .valid    (cap_valid),
        .out_src  (cap_src),
        .out_dst  (cap_dst),
        .out_cmd  (cap_cmd),
        .out_addr (cap_addr),
        .out_data (cap_data)
    );

endmodule

// File: tb/tb_ring_stop.sv
module tb_ring_stop;

    localparam int ME = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_vld = 1'b0;
    logic [2:0]  up_src = '0, up_dst = '0;
    logic [3:0]  up_cmd = '0;
    logic [15:0] up_addr = '0;
    logic [31:0] up_data = '0;
    logic        dn_vld;
    logic [2:0]  dn_src, dn_dst;
    logic [3:0]  dn_cmd;
    logic [15:0] dn_addr;
    logic [31:0] dn_data;
    logic        tx_valid = 1'b0, tx_ready;
    logic [2:0]  tx_dst = '0;
    logic [3:0]  tx_cmd = '0;
    logic [15:0] tx_addr = '0;
    logic [31:0] tx_data = '0;
    logic        rx_valid, rx_ready = 1'b0;
    logic [2:0]  rx_src;
    logic [3:0]  rx_cmd;
    logic [15:0] rx_addr;
    logic [31:0] rx_data;
    logic        cap_en = 1'b0;
    logic [3:0]  cap_cmd_val = '0, cap_cmd_mask = '0;
    logic [2:0]  cap_dst_val = '0, cap_dst_mask = '0;
    logic        cap_valid, cap_pop = 1'b0;
    logic [2:0]  cap_src, cap_dst;
    logic [3:0]  cap_cmd;
    logic [15:0] cap_addr;
    logic [31:0] cap_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ring_stop dut (
        .clk(clk), .rst_n(rst_n),
        .up_vld(up_vld), .up_src(up_src), .up_dst(up_dst), .up_cmd(up_cmd),
        .up_addr(up_addr), .up_data(up_data),
        .dn_vld(dn_vld), .dn_src(dn_src), .dn_dst(dn_dst), .dn_cmd(dn_cmd),
        .dn_addr(dn_addr), .dn_data(dn_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_dst(tx_dst), .tx_cmd(tx_cmd),
        .tx_addr(tx_addr), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_src(rx_src), .rx_cmd(rx_cmd),
        .rx_addr(rx_addr), .rx_data(rx_data),
        .cap_en(cap_en), .cap_cmd_val(cap_cmd_val), .cap_cmd_mask(cap_cmd_mask),
        .cap_dst_val(cap_dst_val), .cap_dst_mask(cap_dst_mask),
        .cap_valid(cap_valid), .cap_pop(cap_pop), .cap_src(cap_src),
        .cap_dst(cap_dst), .cap_cmd(cap_cmd), .cap_addr(cap_addr), .cap_data(cap_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic slot(input bit v, input logic [2:0] s, input logic [2:0] d,
                        input logic [3:0] c, input logic [15:0] a, input logic [31:0] dt);
        up_vld = v; up_src = s; up_dst = d; up_cmd = c; up_addr = a; up_data = dt;
    endtask

    task automatic offer(input bit v, input logic [2:0] d, input logic [3:0] c,
                         input logic [15:0] a, input logic [31:0] dt);
        tx_valid = v; tx_dst = d; tx_cmd = c; tx_addr = a; tx_data = dt;
    endtask

    task automatic t_reset();
        chk(dn_vld == 1'b0, "R1 dn_vld", 64'(dn_vld), 0);
        chk(tx_ready == 1'b1, "R1 tx_ready", 64'(tx_ready), 1);
        chk(cap_valid == 1'b0, "R1 cap_valid", 64'(cap_valid), 0);
        chk(rx_valid == 1'b0, "R1 rx_valid", 64'(rx_valid), 0);
    endtask

    task automatic t_forward();
        for (int i = 0; i < 3; i++) begin
            slot(1, 3'(i), 3'(5 + (i % 2)), 4'(i + 7), 16'h1000 + 16'(i), 32'hA0A0_0000 + 32'(i));
            chk(rx_valid == 1'b0, "R2 no rx for foreign", 64'(rx_valid), 0);
            tick();
            chk(dn_vld && dn_src == 3'(i) && dn_dst == 3'(5 + (i % 2)) && dn_cmd == 4'(i + 7),
                "R2 header forwarded", {dn_src, dn_dst, dn_cmd}, 64'(i));
            chk(dn_addr == 16'h1000 + 16'(i) && dn_data == 32'hA0A0_0000 + 32'(i),
                "R2 payload forwarded", 64'(dn_data), 32'hA0A0_0000 + 32'(i));
        end
        slot(0, 0, 0, 0, 0, 0);
        tick();
    endtask

    task automatic t_receive();
        rx_ready = 1;
        slot(1, 3'd4, 3'(ME), 4'd9, 16'h2222, 32'h1234_5678);
        #1;
        chk(rx_valid && rx_src == 3'd4 && rx_cmd == 4'd9 && rx_addr == 16'h2222 &&
            rx_data == 32'h1234_5678, "R3 rx fields", 64'(rx_data), 32'h1234_5678);
        tick();
        chk(dn_vld == 1'b0, "R3 slot emptied", 64'(dn_vld), 0);
        rx_ready = 0;
        slot(0, 0, 0, 0, 0, 0);
        tick();
    endtask

    task automatic t_backpressure();
        rx_ready = 0;
        slot(1, 3'd1, 3'(ME), 4'd3, 16'h3333, 32'hCAFE_0001);
        #1;
        chk(rx_valid == 1'b1, "R4 rx_valid offered", 64'(rx_valid), 1);
        tick();
        chk(dn_vld && dn_dst == 3'(ME) && dn_src == 3'd1 && dn_data == 32'hCAFE_0001,
            "R4 kept on ring", 64'(dn_data), 32'hCAFE_0001);
        slot(0, 0, 0, 0, 0, 0);
        tick();
    endtask

    task automatic t_transmit();
        offer(1, 3'd6, 4'd5, 16'h4444, 32'hBEEF_0001);
        slot(1, 3'd0, 3'd7, 4'd1, 16'h0001, 32'h0000_00F1);
        tick();
        offer(0, 0, 0, 0, 0);
        chk(dn_vld && dn_data == 32'h0000_00F1, "R5 busy slot forwarded", 64'(dn_data), 32'hF1);
        slot(1, 3'd3, 3'd7, 4'd1, 16'h0002, 32'h0000_00F2);
        tick();
        chk(dn_vld && dn_data == 32'h0000_00F2, "R5 head waits on busy slot", 64'(dn_data), 32'hF2);
        slot(0, 0, 0, 0, 0, 0);
        tick();
        chk(dn_vld && dn_src == 3'(ME) && dn_dst == 3'd6 && dn_cmd == 4'd5 &&
            dn_addr == 16'h4444 && dn_data == 32'hBEEF_0001,
            "R5 inserted in empty slot", 64'(dn_data), 32'hBEEF_0001);
        tick();
        chk(dn_vld == 1'b0, "R5 sent once", 64'(dn_vld), 0);
    endtask

    task automatic t_reuse();
        offer(1, 3'd1, 4'd2, 16'h5555, 32'hD00D_0001);
        slot(1, 3'd0, 3'd7, 4'd1, 16'h0, 32'h77);
        tick();
        offer(0, 0, 0, 0, 0);
        rx_ready = 1;
        slot(1, 3'd5, 3'(ME), 4'd4, 16'h6666, 32'h0BAD_F00D);
        #1;
        chk(rx_valid && rx_data == 32'h0BAD_F00D, "R6 rx accepted", 64'(rx_data), 32'h0BADF00D);
        tick();
        chk(dn_vld && dn_src == 3'(ME) && dn_data == 32'hD00D_0001,
            "R6 freed slot reused", 64'(dn_data), 32'hD00D_0001);
        rx_ready = 0;
        slot(0, 0, 0, 0, 0, 0);
        tick();
        chk(dn_vld == 1'b0, "R6 queue drained", 64'(dn_vld), 0);
    endtask

    task automatic t_order_full();
        slot(1, 3'd0, 3'd7, 4'd1, 16'h0, 32'h0);
        for (int i = 0; i < 4; i++) begin
            offer(1, 3'd3, 4'd6, 16'h7000 + 16'(i), 32'h5000 + 32'(i));
            tick();
        end
        chk(tx_ready == 1'b0, "R7 tx_ready low when full", 64'(tx_ready), 0);
        offer(1, 3'd3, 4'd6, 16'h7FFF, 32'h0000_0BAD);
        tick();
        offer(0, 0, 0, 0, 0);
        slot(0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(dn_vld && dn_data == 32'h5000 + 32'(i), "R7 push order", 64'(dn_data),
                64'(32'h5000 + 32'(i)));
        end
        tick();
        chk(dn_vld == 1'b0, "R7 offer while full discarded", 64'(dn_vld), 0);
    endtask

    task automatic t_capture();
        cap_en = 1; cap_cmd_val = 4'd3; cap_cmd_mask = 4'hF; cap_dst_mask = 3'd0;
        slot(1, 3'd1, 3'd6, 4'd3, 16'h0A, 32'hAAAA_0001); tick();
        slot(1, 3'd1, 3'd6, 4'd5, 16'h0B, 32'hAAAA_0002); tick();
        slot(1, 3'd1, 3'd4, 4'd3, 16'h0C, 32'hAAAA_0003); tick();
        slot(0, 0, 0, 0, 0, 0);
        chk(cap_valid && cap_cmd == 4'd3 && cap_data == 32'hAAAA_0001,
            "R8 first match", 64'(cap_data), 32'hAAAA0001);
        cap_pop = 1; tick(); cap_pop = 0;
        chk(cap_valid && cap_dst == 3'd4 && cap_data == 32'hAAAA_0003,
            "R8 second match, non-match skipped", 64'(cap_data), 32'hAAAA0003);
        cap_pop = 1; tick(); cap_pop = 0;
        chk(cap_valid == 1'b0, "R8 buffer empty", 64'(cap_valid), 0);
        cap_cmd_mask = 4'h0; cap_dst_val = 3'd6; cap_dst_mask = 3'h7;
        slot(1, 3'd2, 3'd4, 4'd8, 16'h0D, 32'hBBBB_0001); tick();
        slot(1, 3'd2, 3'd6, 4'd9, 16'h0E, 32'hBBBB_0002); tick();
        slot(0, 0, 0, 0, 0, 0);
        chk(cap_valid && cap_src == 3'd2 && cap_addr == 16'h0E && cap_data == 32'hBBBB_0002,
            "R8 recipient mask", 64'(cap_data), 32'hBBBB0002);
        cap_pop = 1; tick(); cap_pop = 0;
        chk(cap_valid == 1'b0, "R8 only one recipient match", 64'(cap_valid), 0);
    endtask

    task automatic t_cap_full();
        cap_en = 1; cap_cmd_val = 4'd3; cap_cmd_mask = 4'hF; cap_dst_mask = 3'd0;
        for (int i = 0; i < 6; i++) begin
            slot(1, 3'd1, 3'd6, 4'd3, 16'h0, 32'h100 + 32'(i));
            tick();
        end
        slot(0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) begin
            chk(cap_valid && cap_data == 32'h100 + 32'(i), "R9 oldest kept",
                64'(cap_data), 64'(32'h100 + 32'(i)));
            cap_pop = 1; tick(); cap_pop = 0;
        end
        chk(cap_valid == 1'b0, "R9 overflow dropped", 64'(cap_valid), 0);
    endtask

    task automatic t_cap_off();
        cap_en = 0; cap_cmd_val = 4'd3; cap_cmd_mask = 4'hF;
        slot(1, 3'd1, 3'd6, 4'd3, 16'h0, 32'h999);
        tick();
        slot(0, 0, 0, 0, 0, 0);
        tick();
        chk(cap_valid == 1'b0, "R10 disabled captures nothing", 64'(cap_valid), 0);
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_forward();
        t_receive();
        t_backpressure();
        t_transmit();
        t_reuse();
        t_order_full();
        t_capture();
        t_cap_full();
        t_cap_off();
        done = 1;
        summary();
        $finish;
    end

endmodule